// File: doc/BRIEF.md
# Dual-Operand Funnel Barrel Shifter

This block is a combinational shifter fed by two operands. A single shift amount selects, for every output bit, one of the eight bit positions that it could take from the pair of operands. In a left shift the first operand (A) supplies the bits that survive, and the second operand (B) supplies the bits that enter at the low end. In a right shift the roles are mirrored: B supplies the surviving bits and A supplies the bits that enter at the high end.

Before the operands reach the multiplexers, each one passes through its own conditioner, which can clear it, invert it, or force it to all ones (clear and invert together). One datapath serves every mode:

- **Rotate:** place the same value on both operands.
- **Logical shift:** clear the filling operand.
- **Shift with ones fill:** force the filling operand to all ones.

The block has no clock. The result follows the inputs combinationally.

Top module: `funnel_shifter`

## Requirements
- R1: With `dir_right`=0 and amount k, `result[i]` is conditioned A bit `i-k` for `i>=k`, and conditioned B bit `8+i-k` otherwise. This equals bits 15..8 of `{A,B} << k`.
- R2: With `dir_right`=1 and amount k, `result[i]` is conditioned B bit `i+k` for `i+k<8`, and conditioned A bit `i+k-8` otherwise. This equals bits 7..0 of `{A,B} >> k`.
- R3: An amount of 0 passes the primary operand through unchanged after conditioning. The primary operand is A when `dir_right`=0 and B when `dir_right`=1.
- R4: When both conditioned operands are equal, the result is a circular rotate of that value. Bits leaving the MSB wrap into the LSB on a left shift, and bits leaving the LSB wrap into the MSB on a right shift.
- R5: An operand with clear=1 and invert=0 is all zeros, so a shift fills with zeros from that operand.
- R6: An operand with clear=1 and invert=1 is all ones, so a shift fills with ones from that operand.
- R7: An operand with clear=0 and invert=1 is the bitwise complement of its input.
- R8: The A controls affect only operand A and the B controls affect only operand B. A control on one operand has no effect on the bits the result takes from the other.
- R9: The result depends only on the present inputs and changes in the same cycle that the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 8 | Operand A: the primary operand for a left shift, the fill operand for a right shift |
| opb | input | 8 | Operand B: the fill operand for a left shift, the primary operand for a right shift |
| a_clr | input | 1 | Clear operand A before the shift |
| a_inv | input | 1 | Invert operand A after the clear stage |
| b_clr | input | 1 | Clear operand B before the shift |
| b_inv | input | 1 | Invert operand B after the clear stage |
| shamt | input | 3 | Shift amount, 0 to 7 |
| dir_right | input | 1 | 0 selects a left shift, 1 selects a right shift |
| result | output | 8 | Shifted result |

## Verification
The block is driven with the following patterns, each chosen to expose a different class of fault:

- **Equal operands** (single-bit and asymmetric values): a rotate exposes a wrong wrap direction or an off-by-one tap.
- **A cleared or forced to ones in a right shift, B cleared or forced to ones in a left shift:** the fill bits show whether the fill operand is wired to the correct end.
- **Distinct non-trivial values on A and B:** tap errors that stay hidden under identical operands become visible.
- **Each conditioner control set on one operand only:** shows that the controls do not leak between operands.

Every amount is swept in both directions against a reference built on a 16-bit concatenation.

// File: rtl/fs_pkg.sv
package fs_pkg;

    localparam int DATA_W = 8;
    localparam int AMT_W  = $clog2(DATA_W);

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } shift_dir_e;

    typedef struct packed {
        logic clr;
        logic inv;
    } cond_ctl_t;

    // Clear stage first, then invert stage; clear+invert yields all ones.
    function automatic logic [DATA_W-1:0] cond_apply(
        input logic [DATA_W-1:0] val,
        input cond_ctl_t         ctl
    );
        logic [DATA_W-1:0] cleared;
        cleared = ctl.clr ? '0 : val;
        return ctl.inv ? ~cleared : cleared;
    endfunction

endpackage

// File: rtl/fs_cond.sv
module fs_cond
    import fs_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] din,
    input  cond_ctl_t    ctl,
    output logic [W-1:0] dout
);

    logic [W-1:0] after_clr;

    always_comb begin
        after_clr = ctl.clr ? '0 : din;
        dout      = ctl.inv ? ~after_clr : after_clr;
    end

    always_comb begin
        if (!$isunknown({din, ctl})) begin
            if (ctl.clr && !ctl.inv)
                assert_clear_zero_R5: assert (dout == '0)
                    else $error("conditioner clear did not give zeros");
            if (ctl.clr && ctl.inv)
                assert_set_ones_R6: assert (&dout)
                    else $error("conditioner set did not give ones");
            if (!ctl.clr && ctl.inv)
                assert_invert_R7: assert (((dout & din) == '0) && (&(dout | din)))
                    else $error("conditioner invert is not a complement");
        end
    end

endmodule

// File: rtl/fs_tap_mux.sv
module fs_tap_mux #(
    parameter int N     = 8,
    parameter int SEL_W = $clog2(N)
) (
    input  logic [N-1:0]     taps,
    input  logic [SEL_W-1:0] sel,
    output logic             y
);

    always_comb begin
        y = taps[sel];
    end

endmodule

// File: rtl/fs_funnel_core.sv
module fs_funnel_core
    import fs_pkg::*;
#(
    parameter int W   = DATA_W,
    parameter int SW  = $clog2(W)
) (
    input  logic [W-1:0]  hi_op,
    input  logic [W-1:0]  lo_op,
    input  logic [SW-1:0] amt,
    input  shift_dir_e    dir,
    output logic [W-1:0]  res
);

    // Each output bit owns one W-to-1 mux; the tap order is the shift amount.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [W-1:0] left_taps;
        logic [W-1:0] right_taps;
        logic [W-1:0] taps;

        for (genvar k = 0; k < W; k++) begin : g_tap
            if (i >= k) begin : g_l_hi
                assign left_taps[k] = hi_op[i-k];
            end else begin : g_l_lo
                assign left_taps[k] = lo_op[W+i-k];
            end
            if (i + k < W) begin : g_r_lo
                assign right_taps[k] = lo_op[i+k];
            end else begin : g_r_hi
                assign right_taps[k] = hi_op[i+k-W];
            end
        end

        assign taps = (dir == DIR_RIGHT) ? right_taps : left_taps;

        fs_tap_mux #(.N(W), .SEL_W(SW)) u_mux (
            .taps (taps),
            .sel  (amt),
            .y    (res[i])
        );
    end

    logic [2*W-1:0] dbl_hi;
    logic [2*W-1:0] dbl_lo;
    logic [2*W-1:0] rot_l;
    logic [2*W-1:0] rot_r;

    always_comb begin
        dbl_hi = {hi_op, hi_op};
        dbl_lo = {lo_op, lo_op};
        rot_l  = dbl_hi << amt;
        rot_r  = dbl_lo >> amt;
    end

    always_comb begin
        if (!$isunknown({hi_op, lo_op, amt, dir})) begin
            if (amt == '0 && dir == DIR_LEFT)
                assert_pass_left_R3: assert (res == hi_op)
                    else $error("zero amount left did not pass A");
            if (amt == '0 && dir == DIR_RIGHT)
                assert_pass_right_R3: assert (res == lo_op)
                    else $error("zero amount right did not pass B");
            if (hi_op == lo_op && dir == DIR_LEFT)
                assert_rotate_left_R4: assert (res == rot_l[2*W-1:W])
                    else $error("left rotate mismatch");
            if (hi_op == lo_op && dir == DIR_RIGHT)
                assert_rotate_right_R4: assert (res == rot_r[W-1:0])
                    else $error("right rotate mismatch");
        end
    end

endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter
    import fs_pkg::*;
(
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              a_clr,
    input  logic              a_inv,
    input  logic              b_clr,
    input  logic              b_inv,
    input  logic [AMT_W-1:0]  shamt,
    input  logic              dir_right,
    output logic [DATA_W-1:0] result
);

    cond_ctl_t         a_ctl;
    cond_ctl_t         b_ctl;
    logic [DATA_W-1:0] a_cond;
    logic [DATA_W-1:0] b_cond;
    shift_dir_e        dir;

    always_comb begin
        a_ctl = '{clr: a_clr, inv: a_inv};
        b_ctl = '{clr: b_clr, inv: b_inv};
        dir   = dir_right ? DIR_RIGHT : DIR_LEFT;
    end

    fs_cond #(.W(DATA_W)) u_cond_a (
        .din  (opa),
        .ctl  (a_ctl),
        .dout (a_cond)
    );

    fs_cond #(.W(DATA_W)) u_cond_b (
        .din  (opb),
        .ctl  (b_ctl),
        .dout (b_cond)
    );

    fs_funnel_core #(.W(DATA_W), .SW(AMT_W)) u_core (
        .hi_op (a_cond),
        .lo_op (b_cond),
        .amt   (shamt),
        .dir   (dir),
        .res   (result)
    );

    // Independence of the conditioners: a left shift with no fill taken
    // (amount 0) shows A alone; the same holds for B on the right.
    always_comb begin
        if (!$isunknown({opa, opb, a_clr, a_inv, b_clr, b_inv, shamt, dir_right})) begin
            if (shamt == '0 && !dir_right)
                assert_a_only_R8: assert (result == cond_apply(opa, a_ctl))
                    else $error("B controls leaked into A path");
            if (shamt == '0 && dir_right)
                assert_b_only_R8: assert (result == cond_apply(opb, b_ctl))
                    else $error("A controls leaked into B path");
        end
    end

endmodule

// File: tb/funnel_shifter_tb.sv
module funnel_shifter_tb;

    logic       clk = 1'b0;
    logic [7:0] opa, opb;
    logic       a_clr, a_inv, b_clr, b_inv;
    logic [2:0] shamt;
    logic       dir_right;
    logic [7:0] result;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    funnel_shifter u_dut (
        .opa(opa), .opb(opb),
        .a_clr(a_clr), .a_inv(a_inv), .b_clr(b_clr), .b_inv(b_inv),
        .shamt(shamt), .dir_right(dir_right), .result(result)
    );

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] b;
        logic       ac;
        logic       ai;
        logic       bc;
        logic       bi;
        logic [2:0] amt;
        logic       dir;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'h81, 8'h81, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0},
        '{8'hB4, 8'h77, 1'b0, 1'b0, 1'b1, 1'b0, 3'd3, 1'b0},
        '{8'hB4, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 3'd3, 1'b0},
        '{8'h99, 8'hB4, 1'b1, 1'b0, 1'b0, 1'b0, 3'd2, 1'b1},
        '{8'h00, 8'hB4, 1'b1, 1'b1, 1'b0, 1'b0, 3'd2, 1'b1},
        '{8'h01, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1},
        '{8'hC3, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 3'd5, 1'b0},
        '{8'hC3, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 3'd5, 1'b1},
        '{8'h0F, 8'hAA, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0},
        '{8'hFF, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0}
    };

    function automatic logic [7:0] model(
        logic [7:0] a, logic [7:0] b,
        logic ac, logic ai, logic bc, logic bi,
        logic [2:0] amt, logic dir
    );
        logic [7:0]  ca, cb;
        logic [15:0] wide, shl, shr;
        ca   = ac ? 8'h00 : a;
        ca   = ai ? ~ca : ca;
        cb   = bc ? 8'h00 : b;
        cb   = bi ? ~cb : cb;
        wide = {ca, cb};
        shl  = wide << amt;
        shr  = wide >> amt;
        return dir ? shr[7:0] : shl[15:8];
    endfunction

    task automatic drive(
        logic [7:0] a, logic [7:0] b,
        logic ac, logic ai, logic bc, logic bi,
        logic [2:0] amt, logic dir
    );
        @(posedge clk);
        opa = a; opb = b; a_clr = ac; a_inv = ai; b_clr = bc; b_inv = bi;
        shamt = amt; dir_right = dir;
        @(negedge clk);
    endtask

    task automatic check(string req, logic [7:0] exp);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL %s: result=%02h expected=%02h", req, result, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Start-up state: amount zero, left, no conditioning passes A (R3, R9)
        drive(8'h5A, 8'hFF, 0, 0, 0, 0, 3'd0, 0);
        check("R3 initial pass A", 8'h5A);

        // Vector table against the reference model (R1 left, R2 right)
        for (int v = 0; v < NV; v++) begin
            drive(VECS[v].a, VECS[v].b, VECS[v].ac, VECS[v].ai,
                  VECS[v].bc, VECS[v].bi, VECS[v].amt, VECS[v].dir);
            check(VECS[v].dir ? "R2 table" : "R1 table",
                  model(VECS[v].a, VECS[v].b, VECS[v].ac, VECS[v].ai,
                        VECS[v].bc, VECS[v].bi, VECS[v].amt, VECS[v].dir));
        end

        // Full sweep of amounts in both directions with distinct operands
        for (int k = 0; k < 8; k++) begin
            drive(8'hD2, 8'h4B, 0, 0, 0, 0, k[2:0], 0);
            check("R1 sweep", model(8'hD2, 8'h4B, 0, 0, 0, 0, k[2:0], 0));
            drive(8'hD2, 8'h4B, 0, 0, 0, 0, k[2:0], 1);
            check("R2 sweep", model(8'hD2, 8'h4B, 0, 0, 0, 0, k[2:0], 1));
        end

        // Hand-computed corner cases
        drive(8'h81, 8'h81, 0, 0, 0, 0, 3'd1, 0);
        check("R4 rotate left wrap", 8'h03);
        drive(8'h01, 8'h01, 0, 0, 0, 0, 3'd1, 1);
        check("R4 rotate right wrap", 8'h80);
        drive(8'hB4, 8'h77, 0, 0, 1, 0, 3'd3, 0);
        check("R5 zero fill left", 8'hA0);
        drive(8'h99, 8'hB4, 1, 0, 0, 0, 3'd2, 1);
        check("R5 zero fill right", 8'h2D);
        drive(8'hB4, 8'h00, 0, 0, 1, 1, 3'd3, 0);
        check("R6 ones fill left", 8'hA7);
        drive(8'h00, 8'hB4, 1, 1, 0, 0, 3'd2, 1);
        check("R6 ones fill right", 8'hED);
        drive(8'h0F, 8'hAA, 0, 1, 0, 0, 3'd0, 0);
        check("R7 invert A", 8'hF0);
        drive(8'h12, 8'h3C, 0, 0, 0, 1, 3'd0, 1);
        check("R7 invert B", 8'hC3);
        drive(8'h5A, 8'hFF, 1, 0, 0, 0, 3'd0, 1);
        check("R3 pass B right", 8'hFF);

        // Controls on one operand do not touch the other (R8)
        drive(8'h96, 8'h3C, 0, 0, 1, 1, 3'd0, 0);
        check("R8 B ctl no effect on A", 8'h96);
        drive(8'h96, 8'h3C, 1, 1, 0, 0, 3'd0, 1);
        check("R8 A ctl no effect on B", 8'h3C);
        drive(8'hFF, 8'h3C, 1, 0, 0, 0, 3'd4, 0);
        check("R8 A cleared, B kept", 8'h03);

        // Same-cycle response: change input mid-cycle and sample (R9)
        @(posedge clk);
        opa = 8'h81; opb = 8'h81; a_clr = 0; a_inv = 0; b_clr = 0; b_inv = 0;
        shamt = 3'd7; dir_right = 0;
        #1;
        check("R9 combinational response", 8'hC0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule